// File: doc/BRIEF.md
# Serial Absolute Position Reader

This block is a clocked serial master. It reads one absolute position word from an external rotary encoder. A request starts a single read. The block drives the encoder's clock line and shifts in the reply. It returns the word as separate multiturn and singleturn values, together with a one-cycle completion pulse and a level error flag that covers the most recent read.

Two framings can be chosen for each read. The first is BiSS C, where the block waits for the slave's acknowledge and start bit, skips the control bits, and then checks a CRC that follows the data. The second is SSI, where a fixed number of clock periods shift in the word and there is no check. A 5-bit code sets how the word is split between multiturn and singleturn bits.

A pass-through mode gives an external master direct access to the encoder. The external clock is forwarded to the encoder. The encoder's data replaces the local slave data that the device presents to its own serial logic. In this arrangement the encoder is first in the slave chain. While pass-through mode is active, the block does not start reads of its own.

Top module: `abs_pos_reader`

## Requirements
- R1: After reset, `ma_o` is high, `busy_o`, `done_o` and `err_o` are low, and `mt_o` and `st_o` are zero.
- R2: The length code decodes as follows. A code c from 0 to 24 gives 0 multiturn bits and c singleturn bits. Code 25 gives 8 multiturn bits, code 26 gives 12, code 27 gives 16, and codes 28 to 31 give 24. Every code from 25 to 31 gives 24 singleturn bits. `st_o` holds the last st received bits, and `mt_o` holds the mt bits received before them. Both are zero-extended.
- R3: With `proto_ssi_i`=1, a read issues exactly mt+st clock periods. Data is sampled MSB first, with no CRC. With 0 bits, no periods are issued.
- R4: With `proto_ssi_i`=0, the block samples until it sees a low (acknowledge), then until it sees a high (start bit). It then skips two bits and shifts in the mt+st data bits. After the data come an error bit and a warning bit, both active low, and then 6 CRC bits. The CRC bits are sent inverted and MSB first. The CRC uses polynomial x^6+x+1 with initial value 0, computed over the data bits followed by the error and warning bits.
- R5: A CRC mismatch sets `err_o` at completion and leaves `mt_o` and `st_o` unchanged.
- R6: If no low is seen within TIMEOUT_PERIODS sampled periods while waiting for the acknowledge, the read ends with `err_o` set after exactly that many periods.
- R7: If no high is seen within TIMEOUT_PERIODS sampled periods while waiting for the start bit, the read ends with `err_o` set.
- R8: After the final sampled period, `ma_o` stays high. `done_o` pulses exactly MONO_CYCLES clock cycles after the last rising edge of `ma_o`. `ma_o` is high whenever the block is idle and pass-through is off.
- R9: `busy_o` rises in the cycle after an accepted request and stays high until `done_o`. `done_o` is a one-cycle pulse, and `busy_o` is already low while it is high.
- R10: With `bypass_i`=1, `ma_o` follows `ext_ma_i` and `chain_sl_o` follows `slv_data_i`. Otherwise `chain_sl_o` follows `own_sl_i`.
- R11: A request is ignored while `bypass_i` is high or while a read is in progress. A read already in progress keeps the protocol and length it latched at its start.
- R12: Each clock period has a low phase of CLK_DIV cycles followed by a high phase. Data is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read |
| proto_ssi_i | input | 1 | 0: BiSS C framing, 1: SSI framing |
| len_code_i | input | 5 | Multiturn/singleturn length code |
| bypass_i | input | 1 | Pass-through mode |
| ext_ma_i | input | 1 | External master clock for pass-through |
| own_sl_i | input | 1 | Local slave data of the device |
| slv_data_i | input | 1 | Encoder data line |
| ma_o | output | 1 | Clock line to the encoder |
| chain_sl_o | output | 1 | Slave data presented to the device's serial logic |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error result of the last read |
| mt_o | output | 24 | Multiturn value |
| st_o | output | 24 | Singleturn value |

## Verification
The bench builds the block with CLK_DIV=2, TIMEOUT_PERIODS=6 and MONO_CYCLES=5. With these values a full 48-bit BiSS frame takes about 250 cycles. This is short enough to sweep all 32 length codes under both framings, including the zero-length SSI case and every nonlinear split. The short timeout makes both the acknowledge and start-bit expiry paths reachable. Their exact period counts are checked together with the hold time before completion and the low-phase width.

// File: rtl/abs_pos_pkg.sv
package abs_pos_pkg;
  localparam int MT_MAX  = 24;
  localparam int ST_MAX  = 24;
  localparam int WORD_W  = MT_MAX + ST_MAX;
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int CODE_W  = 5;
  localparam int LEN_W   = 5;
  localparam int CRC_W   = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_START, S_SKIP, S_DATA, S_EW, S_CRC, S_HOLD
  } rd_state_t;
endpackage

// File: rtl/abs_len_decode.sv
module abs_len_decode
  import abs_pos_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  mt_len_o,
  output logic [LEN_W-1:0]  st_len_o
);
  always_comb begin
    if (code_i <= CODE_W'(ST_MAX)) begin
      mt_len_o = '0;
      st_len_o = LEN_W'(code_i);
    end else begin
      st_len_o = LEN_W'(ST_MAX);
      case (code_i)
        5'd25:   mt_len_o = LEN_W'(8);
        5'd26:   mt_len_o = LEN_W'(12);
        5'd27:   mt_len_o = LEN_W'(16);
        default: mt_len_o = LEN_W'(MT_MAX);
      endcase
    end
  end
endmodule

// File: rtl/abs_bit_clock.sv
module abs_bit_clock #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic ma_o,
  output logic rise_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          ma_q, ma_d;
  logic          wrap;

  assign wrap   = (cnt_q == DW'(CLK_DIV - 1));
  assign rise_o = run_i && wrap && !ma_q;
  assign ma_o   = ma_q;

  always_comb begin
    cnt_d = cnt_q;
    ma_d  = ma_q;
    if (!run_i) begin
      cnt_d = '0;
      ma_d  = 1'b1;
    end else if (wrap) begin
      cnt_d = '0;
      ma_d  = !ma_q;
    end else begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ma_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ma_q  <= ma_d;
    end
  end
endmodule

// File: rtl/abs_crc6.sv
module abs_crc6
  import abs_pos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  assign fb    = din_i ^ crc_q[CRC_W-1];
  assign crc_o = crc_q;

  always_comb begin
    crc_d = crc_q;
    if (clr_i)
      crc_d = '0;
    else if (en_i)
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/abs_pos_reader.sv
module abs_pos_reader
  import abs_pos_pkg::*;
#(
  parameter int CLK_DIV         = 4,
  parameter int TIMEOUT_PERIODS = 32,
  parameter int MONO_CYCLES     = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              proto_ssi_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              bypass_i,
  input  logic              ext_ma_i,
  input  logic              own_sl_i,
  input  logic              slv_data_i,
  output logic              ma_o,
  output logic              chain_sl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [MT_MAX-1:0] mt_o,
  output logic [ST_MAX-1:0] st_o
);
  localparam int TO_W = $clog2(TIMEOUT_PERIODS) + 1;
  localparam int MO_W = $clog2(MONO_CYCLES) + 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rd_state_t         state_q, state_d;
  logic              ssi_q, ssi_d;
  logic [LEN_W-1:0]  st_len_q, st_len_d;
  logic [CNT_W-1:0]  nbits_q, nbits_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [TO_W-1:0]   tocnt_q, tocnt_d;
  logic [MO_W-1:0]   mono_q, mono_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CRC_W-2:0]  rxcrc_q, rxcrc_d;
  logic              errp_q, errp_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [MT_MAX-1:0] mt_q, mt_d;
  logic [ST_MAX-1:0] st_q, st_d;

  logic [LEN_W-1:0]  dec_mt, dec_st;
  logic              run, rise, int_ma;
  logic              crc_clr, crc_en;
  logic [CRC_W-1:0]  crc_val;
  logic [CRC_W-1:0]  rx_full;
  logic [ST_MAX-1:0] st_mask;
  logic [MT_MAX-1:0] mt_val;
  logic [ST_MAX-1:0] st_val;
  logic              to_hit;

  abs_len_decode u_dec (
    .code_i   (len_code_i),
    .mt_len_o (dec_mt),
    .st_len_o (dec_st)
  );

  abs_bit_clock #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .ma_o   (int_ma),
    .rise_o (rise)
  );

  abs_crc6 u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .din_i (slv_data_i),
    .crc_o (crc_val)
  );

  assign run     = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign to_hit  = (tocnt_q == TO_W'(TIMEOUT_PERIODS - 1));
  assign rx_full = {rxcrc_q, slv_data_i};
  assign st_mask = ST_MAX'((25'd1 << st_len_q) - 25'd1);
  assign st_val  = sr_q[ST_MAX-1:0] & st_mask;
  assign mt_val  = MT_MAX'(sr_q >> st_len_q);

  always_comb begin
    state_d  = state_q;
    ssi_d    = ssi_q;
    st_len_d = st_len_q;
    nbits_d  = nbits_q;
    bcnt_d   = bcnt_q;
    tocnt_d  = tocnt_q;
    mono_d   = mono_q;
    sr_d     = sr_q;
    rxcrc_d  = rxcrc_q;
    errp_d   = errp_q;
    err_d    = err_q;
    mt_d     = mt_q;
    st_d     = st_q;
    done_d   = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start_i && !bypass_i) begin
          ssi_d    = proto_ssi_i;
          st_len_d = dec_st;
          nbits_d  = CNT_W'(dec_mt) + CNT_W'(dec_st);
          bcnt_d   = '0;
          tocnt_d  = '0;
          mono_d   = '0;
          sr_d     = '0;
          errp_d   = 1'b0;
          crc_clr  = 1'b1;
          if (!proto_ssi_i)
            state_d = S_ACK;
          else if ((CNT_W'(dec_mt) + CNT_W'(dec_st)) == '0)
            state_d = S_HOLD;
          else
            state_d = S_DATA;
        end
      end
      S_ACK, S_START: begin
        if (rise) begin
          if (slv_data_i == (state_q == S_START)) begin
            tocnt_d = '0;
            bcnt_d  = '0;
            state_d = (state_q == S_ACK) ? S_START : S_SKIP;
          end else if (to_hit) begin
            errp_d  = 1'b1;
            mono_d  = '0;
            state_d = S_HOLD;
          end else begin
            tocnt_d = tocnt_q + TO_W'(1);
          end
        end
      end
      S_SKIP: begin
        if (rise) begin
          if (bcnt_q == CNT_W'(1)) begin
            bcnt_d  = '0;
            state_d = (nbits_q == '0) ? S_EW : S_DATA;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      S_DATA: begin
        if (rise) begin
          sr_d   = {sr_q[WORD_W-2:0], slv_data_i};
          crc_en = !ssi_q;
          if (bcnt_q == nbits_q - CNT_W'(1)) begin
            bcnt_d  = '0;
            mono_d  = '0;
            state_d = ssi_q ? S_HOLD : S_EW;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      S_EW: begin
        if (rise) begin
          crc_en = 1'b1;
          if (bcnt_q == CNT_W'(1)) begin
            bcnt_d  = '0;
            state_d = S_CRC;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      S_CRC: begin
        if (rise) begin
          rxcrc_d = rx_full[CRC_W-2:0];
          if (bcnt_q == CNT_W'(CRC_W - 1)) begin
            bcnt_d  = '0;
            mono_d  = '0;
            state_d = S_HOLD;
            if (rx_full != ~crc_val) errp_d = 1'b1;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      S_HOLD: begin
        if (mono_q == MO_W'(MONO_CYCLES - 1)) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          err_d   = errp_q;
          if (!errp_q) begin
            mt_d = mt_val;
            st_d = st_val;
          end
        end else begin
          mono_d = mono_q + MO_W'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= S_IDLE;
      ssi_q    <= 1'b0;
      st_len_q <= '0;
      nbits_q  <= '0;
      bcnt_q   <= '0;
      tocnt_q  <= '0;
      mono_q   <= '0;
      sr_q     <= '0;
      rxcrc_q  <= '0;
      errp_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      mt_q     <= '0;
      st_q     <= '0;
    end else begin
      state_q  <= state_d;
      ssi_q    <= ssi_d;
      st_len_q <= st_len_d;
      nbits_q  <= nbits_d;
      bcnt_q   <= bcnt_d;
      tocnt_q  <= tocnt_d;
      mono_q   <= mono_d;
      sr_q     <= sr_d;
      rxcrc_q  <= rxcrc_d;
      errp_q   <= errp_d;
      done_q   <= done_d;
      err_q    <= err_d;
      mt_q     <= mt_d;
      st_q     <= st_d;
    end
  end

  assign ma_o       = bypass_i ? ext_ma_i : int_ma;
  assign chain_sl_o = bypass_i ? slv_data_i : own_sl_i;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign mt_o       = mt_q;
  assign st_o       = st_q;
endmodule

// File: rtl/abs_pos_reader_chk.sv
module abs_pos_reader_chk
  import abs_pos_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              bypass_i,
  input logic              ma_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [MT_MAX-1:0] mt_o,
  input logic [ST_MAX-1:0] st_o
);
  logic [1:0] age_q;
  logic       live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign live = (age_q == 2'd3);

  // R9
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (start_i && !busy_o && !bypass_i) |=> busy_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $fell(busy_o) |-> done_o);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    done_o |=> !done_o);
  // R5
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (done_o && err_o) |-> (mt_o == $past(mt_o) && st_o == $past(st_o)));
  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!busy_o && !bypass_i) |-> ma_o);
  // R11
  bypass_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (start_i && bypass_i && !busy_o) |=> !busy_o);
endmodule

bind abs_pos_reader abs_pos_reader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .bypass_i (bypass_i),
  .ma_o     (ma_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .mt_o     (mt_o),
  .st_o     (st_o)
);

// File: tb/abs_pos_reader_bench.sv
`timescale 1ns/1ps
module abs_pos_reader_bench;
  localparam int DIV    = 2;
  localparam int TO     = 6;
  localparam int MONO   = 5;
  localparam int ACKLAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, proto, bypass, ext_ma, own_sl, byp_data;
  logic [4:0]  len;
  logic        slv_model;
  logic        slv;
  logic        ma_o, chain_sl_o, busy_o, done_o, err_o;
  logic [23:0] mt_o, st_o;

  assign slv = bypass ? byp_data : slv_model;

  abs_pos_reader #(.CLK_DIV(DIV), .TIMEOUT_PERIODS(TO), .MONO_CYCLES(MONO)) u_abs_pos_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .proto_ssi_i(proto), .len_code_i(len),
    .bypass_i(bypass), .ext_ma_i(ext_ma), .own_sl_i(own_sl), .slv_data_i(slv),
    .ma_o(ma_o), .chain_sl_o(chain_sl_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .mt_o(mt_o), .st_o(st_o)
  );

  int  nvec = 0, nerr = 0;
  bit  seq [0:127];
  int  seq_len = 0;
  logic idle_lvl = 1'b1;
  int  fall_cnt = 0, base = 0, hi_cnt = 0, mono_seen = -1, low_cnt = 0, mk = 0;
  logic prev_ma = 1'b1;
  bit  low_bad = 0;
  int  cyc = 0;

  // encoder model and line monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      fall_cnt = 0; hi_cnt = 0; prev_ma = 1'b1; low_cnt = 0; slv_model = 1'b1;
    end else begin
      if (!bypass && prev_ma && !ma_o) begin
        fall_cnt++;
        mk = fall_cnt - base - 1;
        slv_model = (mk >= 0 && mk < seq_len) ? logic'(seq[mk]) : idle_lvl;
        low_cnt = 1;
      end else if (!ma_o) begin
        low_cnt++;
      end
      if (!bypass && !prev_ma && ma_o) begin
        if (low_cnt != DIV) low_bad = 1;
        hi_cnt = 0;
      end else if (ma_o) begin
        hi_cnt++;
      end
      if (done_o) mono_seen = hi_cnt;
      prev_ma = ma_o;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  // mode: 0 good, 1 bad crc, 2 no acknowledge, 3 no start bit
  task automatic run_frame(input bit ssi, input logic [4:0] code, input logic [47:0] pat,
                           input int mode, input bit restart);
    int mtl, stl, n, p, falls_exp, wcnt;
    logic [5:0] c;
    logic fb, b;
    logic [23:0] old_mt, old_st, exp_mt, exp_st;
    bit exp_err;
    string tag;
    if (code <= 24) begin mtl = 0; stl = int'(code); end
    else begin
      stl = 24;
      mtl = (code == 25) ? 8 : (code == 26) ? 12 : (code == 27) ? 16 : 24;
    end
    n = mtl + stl;
    exp_st = 24'(pat & ((48'd1 << stl) - 48'd1));
    exp_mt = 24'((pat >> stl) & ((48'd1 << mtl) - 48'd1));
    p = 0;
    idle_lvl = 1'b1;
    if (ssi) begin
      for (int i = n - 1; i >= 0; i--) begin seq[p] = pat[i]; p++; end
      falls_exp = n;
      tag = "R3";
    end else if (mode == 2) begin
      falls_exp = TO;
      tag = "R6";
    end else if (mode == 3) begin
      seq[0] = 0; p = 1; idle_lvl = 1'b0;
      falls_exp = 1 + TO;
      tag = "R7";
    end else begin
      for (int i = 0; i < ACKLAT; i++) begin seq[p] = 1; p++; end
      seq[p] = 0; p++; seq[p] = 1; p++; seq[p] = 0; p++; seq[p] = 0; p++;
      c = 6'd0;
      for (int i = n + 1; i >= 0; i--) begin
        b = (i >= 2) ? pat[i-2] : 1'b1;
        if (i >= 2) seq[p] = b; else seq[p] = 1;
        if (i >= 2) p++;
        fb = b ^ c[5];
        c = {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
      end
      seq[p] = 1; p++; seq[p] = 1; p++;
      c = ~c;
      if (mode == 1) c[0] = ~c[0];
      for (int i = 5; i >= 0; i--) begin seq[p] = c[i]; p++; end
      falls_exp = ACKLAT + 12 + n;
      tag = (mode == 1) ? "R5" : "R4";
    end
    seq_len = p;
    exp_err = (!ssi && mode != 0);
    old_mt = mt_o; old_st = st_o;

    @(negedge clk);
    base = fall_cnt; low_bad = 0; mono_seen = -1;
    proto = ssi; len = code; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "busy after request", {63'd0, busy_o}, 64'd1);
    if (restart) begin
      repeat (6) @(negedge clk);
      proto = ~ssi; len = code ^ 5'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wcnt = 0;
    while (!done_o && wcnt < 20000) begin @(negedge clk); wcnt++; end
    chk("R9", "done reached", {63'd0, done_o}, 64'd1);
    chk("R9", "busy low at done", {63'd0, busy_o}, 64'd0);
    @(negedge clk);
    chk("R9", "done single pulse", {63'd0, done_o}, 64'd0);
    chk(tag, "error flag", {63'd0, err_o}, {63'd0, exp_err});
    chk(tag, "clock periods", 64'(fall_cnt - base), 64'(falls_exp));
    if (exp_err) begin
      chk("R5", "mt unchanged", {40'd0, mt_o}, {40'd0, old_mt});
      chk("R5", "st unchanged", {40'd0, st_o}, {40'd0, old_st});
    end else begin
      chk("R2", "multiturn", {40'd0, mt_o}, {40'd0, exp_mt});
      chk("R2", "singleturn", {40'd0, st_o}, {40'd0, exp_st});
    end
    if (falls_exp > 0) chk("R8", "hold before done", 64'(mono_seen), 64'(MONO));
    chk("R12", "low phase width", {63'd0, low_bad}, 64'd0);
    if (restart) begin
      repeat (3) @(negedge clk);
      chk("R11", "no frame from request while busy", {63'd0, busy_o}, 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; proto = 1'b0; len = 5'd0; bypass = 1'b0;
    ext_ma = 1'b1; own_sl = 1'b0; byp_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ma idle", {63'd0, ma_o}, 64'd1);
    chk("R1", "busy", {63'd0, busy_o}, 64'd0);
    chk("R1", "done", {63'd0, done_o}, 64'd0);
    chk("R1", "err", {63'd0, err_o}, 64'd0);
    chk("R1", "mt", {40'd0, mt_o}, 64'd0);
    chk("R1", "st", {40'd0, st_o}, 64'd0);

    for (int code = 0; code < 32; code++) begin
      for (int s = 0; s < 2; s++) begin
        run_frame(s[0], 5'(code),
                  48'hC3A5_5A3C_96E1 + 48'(code) * 48'h1357_9BDF_2468 + 48'(s) * 48'h0F0F_0F0F_0F0F,
                  0, 1'b0);
      end
    end

    run_frame(1'b0, 5'd26, 48'h8421_7BDE_1234, 0, 1'b0);
    run_frame(1'b0, 5'd26, 48'h1111_2222_3333, 1, 1'b0);
    run_frame(1'b0, 5'd27, 48'hFFFF_0000_FFFF, 2, 1'b0);
    run_frame(1'b0, 5'd12, 48'h0000_0000_0ABC, 3, 1'b0);
    run_frame(1'b0, 5'd25, 48'h00A5_5AC3_3C69, 0, 1'b1);
    run_frame(1'b1, 5'd12, 48'h0000_0000_0F3C, 0, 1'b1);

    // pass-through
    @(negedge clk);
    bypass = 1'b1;
    for (int v = 0; v < 2; v++) begin
      ext_ma = v[0]; byp_data = ~v[0];
      #1;
      chk("R10", "clock forwarded", {63'd0, ma_o}, {63'd0, v[0]});
      chk("R10", "data forwarded", {63'd0, chain_sl_o}, {63'd0, ~v[0]});
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "request ignored in pass-through", {63'd0, busy_o}, 64'd0);
    repeat (4) @(negedge clk);
    chk("R11", "no done in pass-through", {63'd0, done_o}, 64'd0);
    ext_ma = 1'b1;
    bypass = 1'b0;
    for (int v = 0; v < 2; v++) begin
      own_sl = v[0]; byp_data = v[0];
      #1;
      chk("R10", "local data selected", {63'd0, chain_sl_o}, {63'd0, v[0]});
    end
    chk("R8", "clock idle high", {63'd0, ma_o}, 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule